// File: doc/BRIEF.md
# Bit-Test Conditional Skip Unit

This block decides, for the two bit-test-and-skip instructions of a small 8-bit accumulator-style core, whether the instruction fetched after the test is annulled. The decoder presents an operation class, a register address and a bit index. The register file returns the addressed byte through the block's read port. The block picks the indexed bit and compares it with the polarity the operation asks for. When the skip is taken, it raises a registered squash flag. That flag turns the next issued instruction into a no-operation. The program counter keeps its normal sequence, so the test costs one extra instruction cycle and never branches to a target.

The instruction stream enters as a plain issue strobe, `issue_valid`. The unit accepts an instruction on every cycle and never applies back-pressure, so it has no ready signal. A cycle with the strobe low carries no instruction. Such a cycle neither consumes a pending squash nor starts a new one. The unit writes no register and no status flag. Its only outputs are the read address, the squash flag and a per-instruction cycle count.

Top module: `bit_skip_unit`

## Requirements
- R1: `rd_addr` equals `reg_addr` in the same cycle, for every address from 0 to 127.
- R2: `bit_sel` (0 to 7) selects bit `bit_sel` of `rd_data`, with bit 0 the least significant. Only that bit affects the decision.
- R3: Operation class 2'b01 (skip when set) with the selected bit at 1 is a taken skip. `cycles` reads 2 in the issue cycle, and `squash` is 1 from the next cycle.
- R4: Operation class 2'b01 with the selected bit at 0 is not taken. `cycles` reads 1, and `squash` stays 0.
- R5: Operation class 2'b10 (skip when clear) is taken when the selected bit is 0 (`cycles` 2, `squash` set on the next cycle). When the bit is 1 it is not taken (`cycles` 1, `squash` stays 0).
- R6: A set `squash` annuls exactly the next cycle with `issue_valid` high. It stays set across cycles with `issue_valid` low, and it clears after the annulled instruction.
- R7: An annulled instruction counts as a no-operation. `cycles` reads 1, and it cannot set `squash` again, even when it is itself a taken skip.
- R8: Operation classes 2'b00 and 2'b11 never set `squash` and report `cycles` 1. A cycle with `issue_valid` low reports `cycles` 0 and does not set `squash`.
- R9: A synchronous active-high `rst` clears `squash` at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is issued this cycle |
| op_class | input | 2 | 01 skip when set, 10 skip when clear, 00/11 any other instruction |
| reg_addr | input | 7 | Register address of the tested register |
| bit_sel | input | 3 | Index of the tested bit |
| rd_addr | output | 7 | Read address to the register file |
| rd_data | input | 8 | Byte returned by the register file |
| squash | output | 1 | The instruction issued now is annulled |
| cycles | output | 2 | Instruction cycles used by the instruction issued now (0 when none) |

## Verification
On every cycle, the assertions check how the squash flag behaves over time. It clears after one issued instruction, holds through idle cycles and clears on reset. They also check that a cycle count of 2 is always followed by a squash, that an annulled slot reports one cycle, and that other instruction classes never start a squash. Only the bench's scenarios can show that the right bit is chosen for each index and that each polarity is decoded correctly. The same holds for the read address path and for the no-chaining rule applied to a skip that is itself annulled.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [1:0] {
    OPC_PLAIN     = 2'b00,
    OPC_SKIP_SET  = 2'b01,
    OPC_SKIP_CLR  = 2'b10,
    OPC_PLAIN_ALT = 2'b11
  } opc_e;
endpackage

// File: rtl/bts_bit_pick.sv
module bts_bit_pick #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_o
);
  logic [DATA_W-1:0] onehot;

  // One-hot decode of the index, then AND-OR reduction.
  for (genvar g = 0; g < DATA_W; g++) begin : g_dec
    assign onehot[g] = (idx_i == IDX_W'(g));
  end

  assign bit_o = |(onehot & data_i);

  always_comb begin
    a_r2_onehot_select: assert ($onehot(onehot));
  end
endmodule

// File: rtl/bts_skip_decide.sv
module bts_skip_decide
  import bts_pkg::*;
(
  input  opc_e op_i,
  input  logic bit_i,
  output logic take_o
);
  always_comb begin
    unique case (op_i)
      OPC_SKIP_SET: take_o = bit_i;
      OPC_SKIP_CLR: take_o = ~bit_i;
      default:      take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bts_squash_reg.sv
module bts_squash_reg (
  input  logic clk,
  input  logic rst,
  input  logic issue_i,
  input  logic take_i,
  output logic squash_o
);
  logic squash_q;

  always_ff @(posedge clk) begin
    if (rst)
      squash_q <= 1'b0;
    else if (issue_i)
      squash_q <= squash_q ? 1'b0 : take_i;
  end

  assign squash_o = squash_q;

  a_r6_clear_after_one: assert property (@(posedge clk) disable iff (rst)
    squash_q && issue_i |=> !squash_q);
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    squash_q && !issue_i |=> squash_q);
  a_r8_idle_no_start: assert property (@(posedge clk) disable iff (rst)
    !squash_q && !issue_i |=> !squash_q);
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !squash_q);
endmodule

// File: rtl/bit_skip_unit.sv
module bit_skip_unit
  import bts_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int CYC_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [1:0]        op_class,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [IDX_W-1:0]  bit_sel,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              squash,
  output logic [CYC_W-1:0]  cycles
);
  opc_e op;
  logic tested_bit;
  logic take;
  logic squash_q;

  assign op      = opc_e'(op_class);
  assign rd_addr = reg_addr;

  bts_bit_pick #(.DATA_W(DATA_W)) u_pick (
    .data_i (rd_data),
    .idx_i  (bit_sel),
    .bit_o  (tested_bit)
  );

  bts_skip_decide u_decide (
    .op_i   (op),
    .bit_i  (tested_bit),
    .take_o (take)
  );

  bts_squash_reg u_squash (
    .clk      (clk),
    .rst      (rst),
    .issue_i  (issue_valid),
    .take_i   (take),
    .squash_o (squash_q)
  );

  assign squash = squash_q;

  // An annulled slot runs as a one-cycle no-operation; a taken skip costs two.
  always_comb begin
    if (!issue_valid)   cycles = CYC_W'(0);
    else if (squash_q)  cycles = CYC_W'(1);
    else if (take)      cycles = CYC_W'(2);
    else                cycles = CYC_W'(1);
  end

  a_r3_two_cycles_then_squash: assert property (@(posedge clk) disable iff (rst)
    cycles == CYC_W'(2) |=> squash);
  a_r7_annulled_is_one_cycle: assert property (@(posedge clk) disable iff (rst)
    squash && issue_valid |-> cycles == CYC_W'(1));
  a_r8_plain_never_squashes: assert property (@(posedge clk) disable iff (rst)
    issue_valid && !squash && (op == OPC_PLAIN || op == OPC_PLAIN_ALT) |=> !squash);
  a_r8_idle_zero_cycles: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |-> cycles == CYC_W'(0));
endmodule

// File: tb/test_bit_skip_unit.sv
module test_bit_skip_unit;
  localparam int PERIOD = 10;
  localparam int NVEC = 12;

  logic       clk = 1'b0;
  logic       rst;
  logic       issue_valid;
  logic [1:0] op_class;
  logic [6:0] reg_addr;
  logic [2:0] bit_sel;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic       squash;
  logic [1:0] cycles;

  int applied = 0;
  int bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  bit_skip_unit i_bit_skip_unit (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .op_class(op_class),
    .reg_addr(reg_addr), .bit_sel(bit_sel), .rd_addr(rd_addr),
    .rd_data(rd_data), .squash(squash), .cycles(cycles)
  );

  // {op[1:0], idx[2:0], data[7:0], cycles[1:0], squash_next}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'b01, 3'd0, 8'h01, 2'd2, 1'b1},
    {2'b01, 3'd0, 8'hFE, 2'd1, 1'b0},
    {2'b01, 3'd7, 8'h80, 2'd2, 1'b1},
    {2'b01, 3'd7, 8'h7F, 2'd1, 1'b0},
    {2'b10, 3'd3, 8'hF7, 2'd2, 1'b1},
    {2'b10, 3'd3, 8'h08, 2'd1, 1'b0},
    {2'b10, 3'd5, 8'h00, 2'd2, 1'b1},
    {2'b01, 3'd4, 8'hFF, 2'd2, 1'b1},
    {2'b10, 3'd6, 8'hFF, 2'd1, 1'b0},
    {2'b00, 3'd2, 8'hFF, 2'd1, 1'b0},
    {2'b11, 3'd0, 8'h00, 2'd1, 1'b0},
    {2'b01, 3'd2, 8'h04, 2'd2, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] op, input logic [2:0] idx,
                       input logic [7:0] d);
    @(negedge clk);
    issue_valid = v; op_class = op; bit_sel = idx; rd_data = d;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD*20000);
    bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    rst = 1'b1; issue_valid = 1'b0; op_class = 2'b00; reg_addr = 7'd0;
    bit_sel = 3'd0; rd_data = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset state squash", squash, 0);
    rst = 1'b0;

    // R1: read address pass-through at both ends of the range
    reg_addr = 7'd0;   #1; chk("R1 addr 0", rd_addr, 0);
    reg_addr = 7'd127; #1; chk("R1 addr 127", rd_addr, 127);
    reg_addr = 7'h55;  #1; chk("R1 addr 0x55", rd_addr, 85);

    // Table: R2 R3 R4 R5 R8
    for (int i = 0; i < NVEC; i++) begin
      drive(1'b1, VEC[i][15:14], VEC[i][13:11], VEC[i][10:3]);
      chk("R2/R3/R4/R5 cycles", cycles, VEC[i][2:1]);
      drive(1'b1, 2'b00, 3'd0, 8'h00);
      chk("R3/R5 squash next", squash, VEC[i][0]);
      if (VEC[i][0]) begin
        chk("R6 annulled cycles", cycles, 1);
        drive(1'b1, 2'b00, 3'd0, 8'h00);
        chk("R6 squash cleared", squash, 0);
      end
    end

    // R7: annulled skip cannot chain
    drive(1'b1, 2'b01, 3'd1, 8'h02);
    chk("R3 taken", cycles, 2);
    drive(1'b1, 2'b01, 3'd1, 8'h02);
    chk("R7 squash on second skip", squash, 1);
    chk("R7 annulled skip cycles", cycles, 1);
    drive(1'b1, 2'b00, 3'd0, 8'h00);
    chk("R7 no chained squash", squash, 0);

    // R6/R8: squash held across idle cycles
    drive(1'b1, 2'b10, 3'd4, 8'h00);
    drive(1'b0, 2'b01, 3'd0, 8'hFF);
    chk("R8 idle cycles zero", cycles, 0);
    chk("R6 squash set", squash, 1);
    drive(1'b0, 2'b00, 3'd0, 8'h00);
    chk("R6 held while idle", squash, 1);
    drive(1'b1, 2'b00, 3'd0, 8'h00);
    chk("R6 still pending at issue", squash, 1);
    chk("R6 annulled cycles", cycles, 1);
    drive(1'b0, 2'b00, 3'd0, 8'h00);
    chk("R6 cleared after one", squash, 0);

    // R8: idle cycle with a taken-looking skip does not start a squash
    drive(1'b0, 2'b01, 3'd0, 8'h01);
    drive(1'b1, 2'b00, 3'd0, 8'h00);
    chk("R8 idle skip ignored", squash, 0);

    // R9: reset while a squash is pending
    drive(1'b1, 2'b01, 3'd6, 8'h40);
    drive(1'b0, 2'b00, 3'd0, 8'h00);
    chk("R9 pending before reset", squash, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 reset clears squash", squash, 0);
    rst = 1'b0;

    finish_run();
  end
endmodule